// File: doc/BRIEF.md
# Serial Line Break Detector

This block watches the receive line of an asynchronous serial port and reports when that line has stayed low far longer than any legal character could hold it. Upstream logic supplies the line already synchronized to the system clock. It also supplies a one-cycle strobe that fires sixteen times per bit period. The detector samples the line only on those strobes.

Software selects the break threshold as a multiple of a character time. The size of a character time depends on whether a parity bit is in use. Two outputs result:

- A level-type status bit that shows whether a break is in progress.
- A one-cycle event that the interrupt logic can latch.

After a break has fired, the detector stays quiet until the line has been continuously high for half a bit period. This guarantees a single event per break, however long the break lasts.

Top module: `uart_break_detect`

## Requirements
- R1: After reset, `break_o` is 0, `break_event_o` is 0, and the detector is armed, so the first qualifying low period produces an event.
- R2: A character time is 16 strobes per bit times 10 bits when `parity_en_i` is 0, or times 11 bits when `parity_en_i` is 1. The threshold in strobes is the selected multiple times this character time.
- R3: `level_i` selects the multiple: 2'b00 gives 2 characters, 2'b01 gives 4, 2'b10 gives 8 and 2'b11 gives 16.
- R4: While armed, a break is recognized on the strobe that makes the run of consecutive low samples exceed the threshold, i.e. the (threshold+1)-th low strobe. One clock later, `break_event_o` pulses and `break_o` goes to 1. After exactly threshold low strobes, neither output is raised.
- R5: A single high sample taken on a strobe restarts the low run from zero.
- R6: Line values present while `tick_i` is 0 are ignored. A low line without strobes never produces a break.
- R7: Each break gives exactly one `break_event_o` pulse, one clock cycle wide, no matter how many further low strobes follow. The low-run counter saturates instead of wrapping.
- R8: After a break, 8 consecutive high strobes rearm the detector. `break_o` returns to 0 one clock after the 8th high strobe, and a later low run can raise a new event.
- R9: A low strobe inside the rearm window restarts the high run. 7 high strobes, then 1 low strobe, then 7 high strobes leave `break_o` at 1 and the detector disarmed.
- R10: `break_o` stays 1 for the whole break and through the rearm window, after the event pulse has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle strobe at 16 times the bit rate |
| rx_i | input | 1 | Synchronized receive line, idle high |
| parity_en_i | input | 1 | 1 when frames carry a parity bit |
| level_i | input | 2 | Break threshold select (2/4/8/16 characters) |
| break_o | output | 1 | Break in progress |
| break_event_o | output | 1 | One-cycle pulse when a break is recognized |

## Verification
The hardest states to reach from the ports are these:

- The exact boundary between threshold and threshold+1 low strobes at the largest setting, which is 2816 strobes with parity at the 16-character level.
- The disarmed window in which a short low blip must restart the rearm count.

The bench reaches them by driving the strobe on every other clock with the line held. It counts strobes exactly and checks the outputs at the strobe count just below and just above each limit. Inside the rearm window, it inserts a single low strobe after seven high ones before completing the count.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;

    // Break level select codes.
    typedef enum logic [1:0] {
        BRK_LVL_2  = 2'b00,
        BRK_LVL_4  = 2'b01,
        BRK_LVL_8  = 2'b10,
        BRK_LVL_16 = 2'b11
    } brk_lvl_e;

    // Strobes in the break threshold for one level/parity pair.
    function automatic int unsigned brk_strobes(
        input int unsigned lvl,
        input int unsigned par,
        input int unsigned osr,
        input int unsigned base_bits
    );
        return (32'd2 << lvl) * (base_bits + par) * osr;
    endfunction

endpackage

// File: rtl/brk_threshold.sv
module brk_threshold
    import uart_brk_pkg::*;
#(
    parameter int unsigned OSR       = 16,
    parameter int unsigned BASE_BITS = 10,
    parameter int unsigned CNT_W     = 12
) (
    input  logic [1:0]       lvl_i,
    input  logic             parity_i,
    output logic [CNT_W-1:0] thr_o
);

    localparam int unsigned N_ENT = 8;

    logic [CNT_W-1:0] thr_tbl [N_ENT];

    // One constant per parity/level pair.
    for (genvar p = 0; p < 2; p++) begin : g_par
        for (genvar l = 0; l < 4; l++) begin : g_lvl
            assign thr_tbl[p*4 + l] = CNT_W'(brk_strobes(l, p, OSR, BASE_BITS));
        end
    end

    assign thr_o = thr_tbl[{parity_i, lvl_i}];

endmodule

// File: rtl/brk_low_counter.sv
module brk_low_counter #(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             rx_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } low_state_t;

    low_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick_i) begin
            if (rx_i) begin
                st_d.cnt = '0;
            end else if (st_q.cnt != CNT_MAX) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    // R5
    low_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && rx_i) |=> (cnt_o == '0));

    // R6
    low_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i |=> $stable(cnt_o));

    // R7
    low_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_o == CNT_MAX) |=> (cnt_o == CNT_MAX || cnt_o == '0));

endmodule

// File: rtl/brk_rearm.sv
module brk_rearm #(
    parameter int unsigned HALF = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic rx_i,
    output logic full_o
);

    localparam int unsigned HW = $clog2(HALF + 1);
    localparam logic [HW-1:0] HALF_C = HW'(HALF);

    typedef struct packed {
        logic [HW-1:0] cnt;
    } hi_state_t;

    hi_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick_i) begin
            if (!rx_i) begin
                st_d.cnt = '0;
            end else if (st_q.cnt != HALF_C) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign full_o = (st_q.cnt == HALF_C);

    // R9
    hi_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !rx_i) |=> !full_o);

endmodule

// File: rtl/uart_break_detect.sv
module uart_break_detect
    import uart_brk_pkg::*;
#(
    parameter int unsigned OSR       = 16,
    parameter int unsigned BASE_BITS = 10,
    parameter int unsigned MAX_MULT  = 16
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       tick_i,
    input  logic       rx_i,
    input  logic       parity_en_i,
    input  logic [1:0] level_i,
    output logic       break_o,
    output logic       break_event_o
);

    localparam int unsigned MAX_THR = MAX_MULT * (BASE_BITS + 1) * OSR;
    localparam int unsigned CNT_W   = $clog2(MAX_THR + 2);
    localparam int unsigned HALF    = OSR / 2;

    typedef struct packed {
        logic armed;
        logic status;
        logic event_p;
    } det_state_t;

    det_state_t st_d, st_q;

    logic [CNT_W-1:0] low_cnt;
    logic [CNT_W-1:0] thr;
    logic             rearm_full;
    logic             over_thr;

    brk_threshold #(
        .OSR       (OSR),
        .BASE_BITS (BASE_BITS),
        .CNT_W     (CNT_W)
    ) u_thr (
        .lvl_i    (level_i),
        .parity_i (parity_en_i),
        .thr_o    (thr)
    );

    brk_low_counter #(
        .CNT_W (CNT_W)
    ) u_low (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_i (tick_i),
        .rx_i   (rx_i),
        .cnt_o  (low_cnt)
    );

    brk_rearm #(
        .HALF (HALF)
    ) u_rearm (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_i (tick_i),
        .rx_i   (rx_i),
        .full_o (rearm_full)
    );

    assign over_thr = (low_cnt > thr);

    always_comb begin
        st_d         = st_q;
        st_d.event_p = 1'b0;
        if (st_q.armed && over_thr) begin
            st_d.event_p = 1'b1;
            st_d.status  = 1'b1;
            st_d.armed   = 1'b0;
        end else if (!st_q.armed && rearm_full) begin
            st_d.armed  = 1'b1;
            st_d.status = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.armed   <= 1'b1;
            st_q.status  <= 1'b0;
            st_q.event_p <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign break_o       = st_q.status;
    assign break_event_o = st_q.event_p;

    // R7
    evt_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        break_event_o |=> !break_event_o);

    // R10
    evt_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        break_event_o |-> break_o);

    // R4
    evt_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(break_o) |-> $past(over_thr));

    // R8
    clr_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(break_o) |-> $past(rearm_full));

endmodule

// File: tb/test_uart_break_detect.sv
`timescale 1ns/1ps
module test_uart_break_detect;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       rx = 1'b1;
    logic       par = 1'b0;
    logic [1:0] lvl = 2'b00;
    logic       brk;
    logic       evt;

    int checks = 0;
    int fails = 0;
    int ev_cnt = 0;
    int run = 0;
    int max_run = 0;

    always #10 clk = ~clk;

    uart_break_detect i_uart_break_detect (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .tick_i        (tick),
        .rx_i          (rx),
        .parity_en_i   (par),
        .level_i       (lvl),
        .break_o       (brk),
        .break_event_o (evt)
    );

    always @(negedge clk) begin
        if (evt) begin
            ev_cnt = ev_cnt + 1;
            run = run + 1;
        end else begin
            run = 0;
        end
        if (run > max_run) max_run = run;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int thr_of(input logic [1:0] l, input logic p);
        return (2 << l) * (10 + p) * 16;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        tick = 1'b0;
        rx = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        ev_cnt = 0;
        max_run = 0;
        @(negedge clk);
    endtask

    task automatic ticks(input logic val, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx = val;
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check(brk == 1'b0, "R1 status after reset", brk, 0);
        check(evt == 1'b0, "R1 event after reset", evt, 0);
        ticks(1'b0, thr_of(2'b00, 1'b0) + 1);
        check(ev_cnt == 1, "R1 armed after reset", ev_cnt, 1);
    endtask

    task automatic t_level(input logic [1:0] l, input logic p);
        int t;
        do_reset();
        lvl = l;
        par = p;
        t = thr_of(l, p);
        ticks(1'b0, t);
        check(brk == 1'b0, "R2 R3 R4 below threshold status", brk, 0);
        check(ev_cnt == 0, "R2 R3 R4 below threshold events", ev_cnt, 0);
        ticks(1'b0, 1);
        check(brk == 1'b1, "R2 R3 R4 over threshold status", brk, 1);
        check(ev_cnt == 1, "R2 R3 R4 over threshold events", ev_cnt, 1);
    endtask

    task automatic t_long();
        do_reset();
        lvl = 2'b00;
        par = 1'b0;
        ticks(1'b0, thr_of(2'b00, 1'b0) + 1);
        ticks(1'b0, 5000);
        check(ev_cnt == 1, "R7 one event per break", ev_cnt, 1);
        check(max_run == 1, "R7 event width", max_run, 1);
        check(brk == 1'b1, "R10 status held", brk, 1);
    endtask

    task automatic t_glitch();
        int t;
        do_reset();
        lvl = 2'b01;
        par = 1'b0;
        t = thr_of(2'b01, 1'b0);
        ticks(1'b0, t);
        ticks(1'b1, 1);
        ticks(1'b0, t);
        check(brk == 1'b0, "R5 high sample restarts", brk, 0);
        check(ev_cnt == 0, "R5 no event", ev_cnt, 0);
        ticks(1'b0, 1);
        check(ev_cnt == 1, "R5 break after full run", ev_cnt, 1);
    endtask

    task automatic t_notick();
        do_reset();
        lvl = 2'b00;
        par = 1'b0;
        @(negedge clk);
        rx = 1'b0;
        repeat (3000) @(negedge clk);
        check(brk == 1'b0, "R6 no strobe no break", brk, 0);
        check(ev_cnt == 0, "R6 no strobe no event", ev_cnt, 0);
        ticks(1'b0, thr_of(2'b00, 1'b0));
        check(brk == 1'b0, "R6 unstrobed lows not counted", brk, 0);
        ticks(1'b0, 1);
        check(brk == 1'b1, "R6 strobed run counted", brk, 1);
    endtask

    task automatic t_rearm();
        int t;
        do_reset();
        lvl = 2'b00;
        par = 1'b1;
        t = thr_of(2'b00, 1'b1);
        ticks(1'b0, t + 1);
        check(ev_cnt == 1, "R4 first break", ev_cnt, 1);
        ticks(1'b1, 7);
        check(brk == 1'b1, "R10 status in rearm window", brk, 1);
        ticks(1'b0, 1);
        ticks(1'b1, 7);
        check(brk == 1'b1, "R9 interrupted rearm", brk, 1);
        ticks(1'b0, t + 1);
        check(ev_cnt == 1, "R9 still disarmed", ev_cnt, 1);
        ticks(1'b1, 7);
        check(brk == 1'b1, "R8 seven highs", brk, 1);
        ticks(1'b1, 1);
        check(brk == 1'b0, "R8 eighth high clears", brk, 0);
        ticks(1'b0, t + 1);
        check(ev_cnt == 2, "R8 new event after rearm", ev_cnt, 2);
        check(brk == 1'b1, "R8 status after rearm", brk, 1);
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_level(2'b00, 1'b0);
        t_level(2'b01, 1'b1);
        t_level(2'b10, 1'b0);
        t_level(2'b11, 1'b1);
        t_long();
        t_glitch();
        t_notick();
        t_rearm();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule